// File: doc/BRIEF.md
# Programmable Raster Display Timing Generator

This block turns a pixel clock into the horizontal and vertical timing of a non-interlaced raster. It runs a pixel counter and a line counter, and from their positions it decodes horizontal and vertical sync, a display-active flag and a once-per-line request to start fetching the pixels of the next line. Every boundary is loaded through a simple register write port and is stored as the pixel or line count minus one. Control software clears the enable, loads the timing registers and then sets the enable again. The counters then restart from the top-left corner.

The sync outputs go through a sync-control register. It can invert each axis to active-low, suppress each axis separately for power-saving blanking, kill both syncs at once, and put a composite sync onto the video path. A separate display-control bit forces the active-video flag low while the syncs keep running.

Register indices on `wr_addr`: 0 control, 1 horizontal total, 2 horizontal display, 3 hsync start, 4 hsync end, 5 hsync end on vsync lines, 6 vertical total, 7 vertical display, 8 vsync start, 9 vsync end, 10 prefetch position, 11 sync control, 12 display control. The write port has no back-pressure. A write with `wr_en` high is taken at the rising clock edge.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, all registers are zero, both counters read 0, and hsync, vsync, csync_video, display_active and fetch_req are all 0.
- R2: Control bit 0 is the timing enable. While it is clear, both counters are held at 0. In the first cycle after it is set, both counters read 0, and they advance on every clock after that.
- R3: The pixel counter counts from 0 up to the horizontal total register and then returns to 0. When it returns to 0, the line counter advances, and the line counter returns to 0 after reaching the vertical total register.
- R4: display_active is 1 only when enable (control bit 0) and refresh (control bit 1) are both set, pixel <= horizontal display register and line <= vertical display register.
- R5: The raw hsync is active when the enable is set and hsync start < pixel <= hsync end. The raw vsync is active when the enable is set and vsync start < line <= vsync end.
- R6: On lines where the raw vsync is active, the hsync end boundary is taken from register 5 instead of register 4.
- R7: fetch_req is 1 for the single cycle in which the pixel counter equals the prefetch position register, provided enable and refresh are both set.
- R8: Writes to registers 1 to 10 are ignored while the enable is set. Control, sync-control and display-control writes always take effect.
- R9: Sync-control bit 3 makes hsync active-low and bit 4 makes vsync active-low.
- R10: Sync-control bit 5 suppresses hsync, bit 6 suppresses vsync and bit 1 suppresses both. A suppressed sync holds its inactive level, which is 1 when that axis is inverted and 0 otherwise.
- R11: csync_video equals sync-control bit 0 AND NOT bit 1 AND (unsuppressed raw hsync OR unsuppressed raw vsync).
- R12: Display-control bit 1 forces display_active to 0.
- R13: Take a 1280-pixel line with front porch 48, sync 112 and back porch 248, loaded as 1687/1279/1327/1439. Its line period is 1688 clocks, and hsync is high for 112 clocks starting at pixel 1328.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index |
| wr_data | input | CW | Register write value |
| pix_x | output | CW | Current pixel counter |
| line_y | output | CW | Current line counter |
| hsync | output | 1 | Horizontal sync after polarity and suppression |
| vsync | output | 1 | Vertical sync after polarity and suppression |
| csync_video | output | 1 | Composite sync for the video path |
| display_active | output | 1 | Pixel lies in the visible area and is not blanked |
| fetch_req | output | 1 | One-clock request to fetch the next line |

## Verification
The minus-one convention is the main risk. A design that compares sync with >= instead of > shifts the pulse by one pixel and widens it. A design that wraps at total+1 stretches every line, and the cycle-by-cycle model exposes both. The bench loads different end values into registers 4 and 5 to catch a generator that ignores the vsync-line end. It writes a new horizontal total while running to catch a register file that lets the raster change mid-frame. It sweeps the sync-control patterns one by one, because swapped inversion and suppression order would leave the wrong resting level on a suppressed sync.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned REG_AW = 4;

  // register indices
  localparam logic [REG_AW-1:0] IDX_CTRL  = 4'd0;
  localparam logic [REG_AW-1:0] IDX_TIM_LO = 4'd1;
  localparam logic [REG_AW-1:0] IDX_TIM_HI = 4'd10;
  localparam logic [REG_AW-1:0] IDX_SYNC  = 4'd11;
  localparam logic [REG_AW-1:0] IDX_DISP  = 4'd12;

  // timing register slots (index minus one)
  typedef enum int unsigned {
    T_HTOT = 0, T_HDISP = 1, T_HSS = 2, T_HSE = 3, T_HSEC = 4,
    T_VTOT = 5, T_VDISP = 6, T_VSS = 7, T_VSE = 8, T_PREF = 9
  } tim_slot_e;
  localparam int unsigned NUM_TIM = 10;

  // bit positions software depends on
  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_REFRESH = 1;
  localparam int unsigned SC_ON_RGB   = 0;
  localparam int unsigned SC_ALL_OFF  = 1;
  localparam int unsigned SC_H_INV    = 3;
  localparam int unsigned SC_V_INV    = 4;
  localparam int unsigned SC_H_OFF    = 5;
  localparam int unsigned SC_V_OFF    = 6;
  localparam int unsigned DC_BLANK    = 1;
  localparam int unsigned SC_W        = 7;
endpackage

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              run,
  output logic              refresh,
  output logic              blank,
  output logic [SC_W-1:0]   sync_ctl,
  output logic [CW-1:0]     tim [NUM_TIM]
);
  logic [1:0]      ctrl_q;
  logic [SC_W-1:0] sync_q;
  logic            blank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      sync_q  <= '0;
      blank_q <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == IDX_CTRL) ctrl_q  <= wr_data[1:0];
      if (wr_addr == IDX_SYNC) sync_q  <= wr_data[SC_W-1:0];
      if (wr_addr == IDX_DISP) blank_q <= wr_data[DC_BLANK];
    end
  end

  // timing registers: frozen while the generator runs
  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    localparam logic [REG_AW-1:0] MY_IDX = REG_AW'(g + 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        tim[g] <= '0;
      else if (wr_en && !ctrl_q[CTL_RUN] && wr_addr == MY_IDX)
        tim[g] <= wr_data;
    end
  end

  assign run      = ctrl_q[CTL_RUN];
  assign refresh  = ctrl_q[CTL_REFRESH];
  assign blank    = blank_q;
  assign sync_ctl = sync_q;
endmodule

// File: rtl/raster_axis.sv
module raster_axis #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] total,
  input  logic [CW-1:0] disp,
  input  logic [CW-1:0] s_start,
  input  logic [CW-1:0] s_end,
  output logic [CW-1:0] cnt,
  output logic          wrap,
  output logic          in_disp,
  output logic          sync_raw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (step) cnt <= (cnt == total) ? '0 : cnt + 1'b1;
  end

  assign wrap     = run && step && (cnt == total);
  assign in_disp  = cnt <= disp;
  assign sync_raw = run && (cnt > s_start) && (cnt <= s_end);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic [CW-1:0]     pix_x,
  output logic [CW-1:0]     line_y,
  output logic              hsync,
  output logic              vsync,
  output logic              csync_video,
  output logic              display_active,
  output logic              fetch_req
);
  logic            run, refresh, blank;
  logic [SC_W-1:0] sync_ctl;
  logic [CW-1:0]   tim [NUM_TIM];
  logic            h_wrap, v_wrap, h_in, v_in, h_raw, v_raw;
  logic [CW-1:0]   h_end_sel;

  raster_regs #(.CW(CW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .run, .refresh, .blank, .sync_ctl, .tim
  );

  // lines inside the vertical sync use the alternate hsync end
  assign h_end_sel = v_raw ? tim[T_HSEC] : tim[T_HSE];

  raster_axis #(.CW(CW)) u_h (
    .clk, .rst_n, .run, .step(1'b1),
    .total(tim[T_HTOT]), .disp(tim[T_HDISP]),
    .s_start(tim[T_HSS]), .s_end(h_end_sel),
    .cnt(pix_x), .wrap(h_wrap), .in_disp(h_in), .sync_raw(h_raw)
  );

  raster_axis #(.CW(CW)) u_v (
    .clk, .rst_n, .run, .step(h_wrap),
    .total(tim[T_VTOT]), .disp(tim[T_VDISP]),
    .s_start(tim[T_VSS]), .s_end(tim[T_VSE]),
    .cnt(line_y), .wrap(v_wrap), .in_disp(v_in), .sync_raw(v_raw)
  );

  logic h_live, v_live;
  assign h_live = h_raw && !sync_ctl[SC_H_OFF] && !sync_ctl[SC_ALL_OFF];
  assign v_live = v_raw && !sync_ctl[SC_V_OFF] && !sync_ctl[SC_ALL_OFF];

  assign hsync          = h_live ^ sync_ctl[SC_H_INV];
  assign vsync          = v_live ^ sync_ctl[SC_V_INV];
  assign csync_video    = sync_ctl[SC_ON_RGB] && (h_live || v_live);
  assign display_active = run && refresh && !blank && h_in && v_in;
  assign fetch_req      = run && refresh && (pix_x == tim[T_PREF]);

  logic unused_vwrap;
  assign unused_vwrap = v_wrap;
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk
  import raster_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              blank,
  input logic [SC_W-1:0]   sync_ctl,
  input logic [CW-1:0]     h_total,
  input logic [CW-1:0]     v_total,
  input logic              wr_en,
  input logic [REG_AW-1:0] wr_addr,
  input logic [CW-1:0]     pix_x,
  input logic [CW-1:0]     line_y,
  input logic              hsync,
  input logic              vsync,
  input logic              display_active,
  input logic              fetch_req
);
  assert_pix_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_x < h_total) |=> (!run || pix_x == $past(pix_x) + 1'b1));

  assert_pix_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_x == h_total) |=> (!run || pix_x == '0));

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pix_x == '0 && line_y == '0));

  assert_fetch_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && h_total != '0 && $stable(h_total)) |=> !fetch_req);

  assert_blank_R12: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> !display_active);

  assert_kill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ctl[SC_ALL_OFF] |-> (hsync == sync_ctl[SC_H_INV] && vsync == sync_ctl[SC_V_INV]));

  assert_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && wr_en && wr_addr >= IDX_TIM_LO && wr_addr <= IDX_TIM_HI)
      |=> ($stable(h_total) && $stable(v_total)));
endmodule

bind raster_timing_gen raster_timing_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .blank(blank), .sync_ctl(sync_ctl),
  .h_total(tim[raster_pkg::T_HTOT]), .v_total(tim[raster_pkg::T_VTOT]),
  .wr_en(wr_en), .wr_addr(wr_addr), .pix_x(pix_x), .line_y(line_y),
  .hsync(hsync), .vsync(vsync), .display_active(display_active),
  .fetch_req(fetch_req)
);

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [CW-1:0] pix_x, line_y;
  logic          hsync, vsync, csync_video, display_active, fetch_req;

  always #5 clk = ~clk;

  raster_timing_gen #(.CW(CW)) dut (.*);

  int checks = 0;
  int errors = 0;

  // bench model
  int m_ctrl = 0, m_sync = 0, m_disp = 0;
  int m_tim [1:10];
  int m_h = 0, m_v = 0;
  string phase = "R1";
  bit pend = 0;
  int pend_a = 0, pend_d = 0;

  task automatic fail(string tag, string sig, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0d expected=%0d (pix %0d line %0d)", tag, sig, act, exp, m_h, m_v);
  endtask

  task automatic compare();
    bit en, hr, vr, hl, vl, e_hs, e_vs, e_cs, e_de, e_fr;
    int he;
    en = m_ctrl[0];
    vr = en && m_v > m_tim[8] && m_v <= m_tim[9];
    he = vr ? m_tim[5] : m_tim[4];
    hr = en && m_h > m_tim[3] && m_h <= he;
    hl = hr && !m_sync[5] && !m_sync[1];
    vl = vr && !m_sync[6] && !m_sync[1];
    e_hs = hl ^ m_sync[3];
    e_vs = vl ^ m_sync[4];
    e_cs = m_sync[0] && (hl || vl);
    e_de = en && m_ctrl[1] && !m_disp[1] && m_h <= m_tim[2] && m_v <= m_tim[7];
    e_fr = en && m_ctrl[1] && m_h == m_tim[10];
    checks++;
    if (pix_x != m_h)           fail({phase, "/R3"}, "pix_x", pix_x, m_h);
    if (line_y != m_v)          fail({phase, "/R3"}, "line_y", line_y, m_v);
    if (hsync != e_hs)          fail({phase, "/R5 R6 R9 R10"}, "hsync", hsync, e_hs);
    if (vsync != e_vs)          fail({phase, "/R5 R9 R10"}, "vsync", vsync, e_vs);
    if (csync_video != e_cs)    fail({phase, "/R11"}, "csync", csync_video, e_cs);
    if (display_active != e_de) fail({phase, "/R4 R12"}, "de", display_active, e_de);
    if (fetch_req != e_fr)      fail({phase, "/R7"}, "fetch", fetch_req, e_fr);
  endtask

  task automatic step();
    bit old_en;
    @(posedge clk);
    old_en = m_ctrl[0];
    if (!old_en) begin
      m_h = 0; m_v = 0;
    end else if (m_h == m_tim[1]) begin
      m_h = 0;
      m_v = (m_v == m_tim[6]) ? 0 : m_v + 1;
    end else m_h++;
    if (pend) begin
      if (pend_a == 0) m_ctrl = pend_d & 3;
      else if (pend_a >= 1 && pend_a <= 10) begin
        if (!old_en) m_tim[pend_a] = pend_d;
      end
      else if (pend_a == 11) m_sync = pend_d & 8'h7f;
      else if (pend_a == 12) m_disp = pend_d & 2;
      pend = 0;
    end
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = CW'(d);
    pend = 1; pend_a = a; pend_d = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic run_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic load(int ht, int hd, int hs, int he, int hec,
                      int vt, int vd, int vs, int ve, int pf);
    wr(1, ht); wr(2, hd); wr(3, hs); wr(4, he); wr(5, hec);
    wr(6, vt); wr(7, vd); wr(8, vs); wr(9, ve); wr(10, pf);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 1; i <= 10; i++) m_tim[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    phase = "R1";
    compare();

    // small raster: 10 pixels x 6 lines, distinct hsync end on vsync lines (R6)
    phase = "R2";
    load(9, 5, 6, 8, 7, 5, 2, 3, 4, 7);
    wr(0, 3);
    if (pix_x != 0 || line_y != 0) begin
      errors++; $display("FAIL R2 restart actual=%0d/%0d expected=0/0", pix_x, line_y);
    end
    checks++;
    phase = "R3";
    run_n(130);

    // sync-control sweep
    phase = "R9";  wr(11, 8'h08); run_n(60);
    wr(11, 8'h10); run_n(60);
    wr(11, 8'h18); run_n(60);
    phase = "R10"; wr(11, 8'h20); run_n(60);
    wr(11, 8'h40); run_n(60);
    wr(11, 8'h02); run_n(60);
    wr(11, 8'h1a); run_n(60);
    wr(11, 8'h38); run_n(60);
    phase = "R11"; wr(11, 8'h01); run_n(60);
    wr(11, 8'h21); run_n(60);
    wr(11, 8'h03); run_n(60);
    phase = "R12"; wr(11, 0); wr(12, 2); run_n(60);
    wr(12, 0); run_n(20);

    // R8: timing write while running is dropped
    phase = "R8";
    wr(1, 4); wr(7, 5);
    run_n(70);

    // R2: disable holds counters, enable without refresh (R4, R7)
    phase = "R2";
    wr(0, 0); run_n(15);
    phase = "R7"; wr(0, 1); run_n(60);
    phase = "R4"; wr(0, 0); wr(1, 6); wr(10, 0); wr(0, 3); run_n(60);

    // R13: reference horizontal timing
    phase = "R13";
    wr(0, 0);
    load(1687, 1279, 1327, 1439, 1439, 1065, 1023, 1024, 1027, 1332);
    wr(0, 3);
    begin
      int hs_cnt, first, period_ok;
      hs_cnt = 0; first = -1;
      for (int i = 0; i < 1687; i++) begin
        if (hsync) begin
          hs_cnt++;
          if (first < 0) first = pix_x;
        end
        step();
      end
      checks++;
      if (hs_cnt != 112) begin
        errors++; $display("FAIL R13 hsync width actual=%0d expected=112", hs_cnt);
      end
      checks++;
      if (first != 1328) begin
        errors++; $display("FAIL R13 hsync start actual=%0d expected=1328", first);
      end
      step();
      period_ok = (pix_x == 0 && line_y == 1);
      checks++;
      if (!period_ok) begin
        errors++; $display("FAIL R13 line period actual=%0d/%0d expected=0/1", pix_x, line_y);
      end
      run_n(1700);
    end
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end
endmodule